// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification Code

This block gathers the interrupt causes of a serial port into one interrupt request line and a four-bit identification code that software reads to learn which cause to service first. Five causes feed it: receive errors, receive data available (or FIFO trigger reached), a character timeout, transmit holding empty, and modem line changes. Each cause has its own enable bit. Each cause has its own pending rule and its own clear rule, and these rules are driven by strobes that mark software accesses to the identification, line status, receive buffer and modem status registers, and writes to the transmit holding register.

The character timeout is produced inside the block. A small state machine, with states `TO_IDLE`, `TO_COUNT` and `TO_FIRED`, counts character-time ticks while the receive FIFO holds data. Its transitions are: `TO_IDLE -> TO_COUNT` when FIFO mode is on and the FIFO is non-empty; `TO_COUNT -> TO_COUNT` with the count restarted on a push or pop; `TO_COUNT -> TO_FIRED` on the last tick of the window; `TO_FIRED -> TO_COUNT` on a push, pop or receive-buffer read; and `TO_COUNT/TO_FIRED -> TO_IDLE` when the FIFO empties or FIFO mode is turned off.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, `iid` is 4'b0001 and `irq` is 0.
- R2: When several enabled causes are pending, `iid` shows the highest one. The codes, from highest priority to lowest, are: receive error 4'b0110; data available 4'b0100; timeout 4'b1100 (this shares the second level, and data available wins over it); transmit empty 4'b0010; modem change 4'b0000.
- R3: Any bit of `lsr_err` (a one-cycle pulse) makes the receive-error cause pending from the next cycle. An `rd_lsr` strobe clears it, unless a new error arrives in the same cycle.
- R4: The data-available cause follows the `rx_avail` level in the same cycle, with no register in the path.
- R5: A cause whose enable bit is 0 never shows in `iid` and never raises `irq`. The timeout cause is gated by `en_rda`.
- R6: In FIFO mode, the timeout becomes pending after TO_CHARS (default 4) `char_tick` pulses during which the FIFO stays non-empty and sees no push or pop. Any push or pop restarts the count.
- R7: A receive-buffer read clears the timeout. Bit 3 of `iid` is never 1 while `fifo_mode` is 0.
- R8: The transmit-empty cause becomes pending on a rising edge of `thr_empty`. A `thr_write` clears it. An `rd_iir` strobe clears it only when `iid` shows 4'b0010 during that read.
- R9: Any bit of `modem_delta` makes the modem cause pending from the next cycle. An `rd_msr` strobe clears it.
- R10: `irq` is always the inverse of `iid[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | FIFO mode active |
| en_rls | input | 1 | Enable for the receive-error cause |
| en_rda | input | 1 | Enable for data available and timeout |
| en_thre | input | 1 | Enable for transmit empty |
| en_msr | input | 1 | Enable for modem change |
| lsr_err | input | 4 | Error pulses: overrun, parity, framing, break |
| rx_avail | input | 1 | Receive data present or trigger level reached |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_pop | input | 1 | Character removed from receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register / FIFO empty |
| thr_write | input | 1 | Write strobe to transmit holding register |
| modem_delta | input | 4 | Change pulses for the four modem inputs |
| rd_iir | input | 1 | Read strobe of identification code |
| rd_lsr | input | 1 | Read strobe of line status |
| rd_rbr | input | 1 | Read strobe of receive buffer |
| rd_msr | input | 1 | Read strobe of modem status |
| iid | output | 4 | Identification code |
| irq | output | 1 | Interrupt request, active high |

## Verification
Enables, `rx_avail` and `fifo_mode` act on `iid` in the same cycle, so the bench changes them and samples 1 ns later with no clock edge in between. Error pulses, modem pulses, `thr_empty` edges, ticks and all read or write strobes pass through exactly one register. For these, the bench drives on a falling edge, lets one rising edge pass, and samples on the next falling edge. The timeout is counted tick by tick, and the bench checks it one tick before the limit and again at the limit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    typedef enum logic [3:0] {
        IID_NONE = 4'b0001,
        IID_RLS  = 4'b0110,
        IID_RDA  = 4'b0100,
        IID_CTO  = 4'b1100,
        IID_THRE = 4'b0010,
        IID_MSR  = 4'b0000
    } iid_e;

    typedef enum logic [1:0] {
        TO_IDLE,
        TO_COUNT,
        TO_FIRED
    } to_state_e;

    typedef struct packed {
        logic rls;
        logic rda;
        logic cto;
        logic thre;
        logic msr;
    } src_t;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr,
    output logic         pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend <= 1'b0;
        else if (|set_vec)   pend <= 1'b1;
        else if (clr)        pend <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
    import uart_irq_pkg::*;
#(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic rx_nonempty,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic rd_rbr,
    input  logic char_tick,
    output logic fired
);
    localparam int CW = $clog2(TO_CHARS + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_CHARS - 1);

    to_state_e state, state_nx;
    logic [CW-1:0] cnt;
    logic          active, touch;

    assign active = fifo_mode && rx_nonempty;
    assign touch  = rx_push || rx_pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TO_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TO_IDLE:  if (active) state_nx = TO_COUNT;
            TO_COUNT: begin
                if (!active)                         state_nx = TO_IDLE;
                else if (!touch && char_tick && cnt == LAST) state_nx = TO_FIRED;
            end
            TO_FIRED: begin
                if (!active)                       state_nx = TO_IDLE;
                else if (touch || rd_rbr)          state_nx = TO_COUNT;
            end
            default:  state_nx = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt <= '0;
        else if (state != TO_COUNT || touch)          cnt <= '0;
        else if (char_tick && cnt != LAST)            cnt <= cnt + 1'b1;
    end

    assign fired = (state == TO_FIRED) && fifo_mode;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  src_t pend,
    output iid_e code
);
    always_comb begin
        if (pend.rls)       code = IID_RLS;
        else if (pend.rda)  code = IID_RDA;
        else if (pend.cto)  code = IID_CTO;
        else if (pend.thre) code = IID_THRE;
        else if (pend.msr)  code = IID_MSR;
        else                code = IID_NONE;
    end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int ERR_BITS   = 4,
    parameter int MODEM_BITS = 4,
    parameter int TO_CHARS   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_mode,
    input  logic                  en_rls,
    input  logic                  en_rda,
    input  logic                  en_thre,
    input  logic                  en_msr,
    input  logic [ERR_BITS-1:0]   lsr_err,
    input  logic                  rx_avail,
    input  logic                  rx_nonempty,
    input  logic                  rx_push,
    input  logic                  rx_pop,
    input  logic                  char_tick,
    input  logic                  thr_empty,
    input  logic                  thr_write,
    input  logic [MODEM_BITS-1:0] modem_delta,
    input  logic                  rd_iir,
    input  logic                  rd_lsr,
    input  logic                  rd_rbr,
    input  logic                  rd_msr,
    output logic [3:0]            iid,
    output logic                  irq
);
    logic rls_pend, msr_pend, thre_pend, cto_fired;
    logic thr_empty_q, thre_rise, thre_clr;
    src_t gated;
    iid_e code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_empty_q <= 1'b1;
        else        thr_empty_q <= thr_empty;
    end

    assign thre_rise = thr_empty && !thr_empty_q;
    assign thre_clr  = thr_write || (rd_iir && code == IID_THRE);

    uart_irq_flag #(.W(ERR_BITS)) u_rls (
        .clk(clk), .rst_n(rst_n), .set_vec(lsr_err), .clr(rd_lsr), .pend(rls_pend));

    uart_irq_flag #(.W(MODEM_BITS)) u_msr (
        .clk(clk), .rst_n(rst_n), .set_vec(modem_delta), .clr(rd_msr), .pend(msr_pend));

    uart_irq_flag #(.W(1)) u_thre (
        .clk(clk), .rst_n(rst_n), .set_vec(thre_rise), .clr(thre_clr), .pend(thre_pend));

    uart_irq_timeout #(.TO_CHARS(TO_CHARS)) u_to (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_nonempty(rx_nonempty),
        .rx_push(rx_push), .rx_pop(rx_pop), .rd_rbr(rd_rbr), .char_tick(char_tick),
        .fired(cto_fired));

    always_comb begin
        gated.rls  = rls_pend  && en_rls;
        gated.rda  = rx_avail  && en_rda;
        gated.cto  = cto_fired && en_rda;
        gated.thre = thre_pend && en_thre;
        gated.msr  = msr_pend  && en_msr;
    end

    uart_irq_prio u_prio (.pend(gated), .code(code));

    assign iid = code;
    assign irq = !code[0];
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_mode,
    input logic       en_rda,
    input logic [3:0] lsr_err,
    input logic       rx_avail,
    input logic       thr_empty,
    input logic       thr_write,
    input logic [3:0] modem_delta,
    input logic       rd_lsr,
    input logic       rd_msr,
    input logic [3:0] iid,
    input logic       irq
);
    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iid inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000});
    // R3
    rls_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && lsr_err == 4'b0) |=> iid != 4'b0110);
    // R4
    rda_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rda && rx_avail && iid != 4'b0110) |-> iid == 4'b0100);
    // R7
    cto_fifo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !iid[3]);
    // R8
    thre_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_write && !$rose(thr_empty)) |=> iid != 4'b0010);
    // R9
    msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && modem_delta == 4'b0) |=> iid != 4'b0000);
    // R10
    irq_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq != iid[0]);
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .en_rda(en_rda),
    .lsr_err(lsr_err), .rx_avail(rx_avail), .thr_empty(thr_empty),
    .thr_write(thr_write), .modem_delta(modem_delta), .rd_lsr(rd_lsr),
    .rd_msr(rd_msr), .iid(iid), .irq(irq));

// File: tb/uart_irq_id_tb.sv
`timescale 1ns/1ps
module uart_irq_id_tb;
    logic clk = 1'b0;
    logic rst_n, fifo_mode, en_rls, en_rda, en_thre, en_msr;
    logic [3:0] lsr_err, modem_delta, iid;
    logic rx_avail, rx_nonempty, rx_push, rx_pop, char_tick;
    logic thr_empty, thr_write, rd_iir, rd_lsr, rd_rbr, rd_msr, irq;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_id u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .en_rls(en_rls),
        .en_rda(en_rda), .en_thre(en_thre), .en_msr(en_msr), .lsr_err(lsr_err),
        .rx_avail(rx_avail), .rx_nonempty(rx_nonempty), .rx_push(rx_push),
        .rx_pop(rx_pop), .char_tick(char_tick), .thr_empty(thr_empty),
        .thr_write(thr_write), .modem_delta(modem_delta), .rd_iir(rd_iir),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr), .iid(iid), .irq(irq));

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1; step(); char_tick = 1'b0; step();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; fifo_mode = 1'b1;
        {en_rls, en_rda, en_thre, en_msr} = 4'hF;
        lsr_err = '0; modem_delta = '0; rx_avail = 0; rx_nonempty = 0;
        rx_push = 0; rx_pop = 0; char_tick = 0; thr_empty = 1; thr_write = 0;
        rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R1 reset code", iid, 4'b0001);
        check("R10 reset irq", {3'b0, irq}, 4'b0000);

        // R3: each error bit sets, line status read clears
        for (int b = 0; b < 4; b++) begin
            lsr_err = 4'(1 << b); step(); lsr_err = '0;
            check("R3 error set", iid, 4'b0110);
            check("R10 irq high", {3'b0, irq}, 4'b0001);
            rd_lsr = 1; step(); rd_lsr = 0;
            check("R3 lsr read clear", iid, 4'b0001);
        end

        // R9: each modem bit sets, modem read clears
        for (int b = 0; b < 4; b++) begin
            modem_delta = 4'(1 << b); step(); modem_delta = '0;
            check("R9 modem set", iid, 4'b0000);
            rd_msr = 1; step(); rd_msr = 0;
            check("R9 msr read clear", iid, 4'b0001);
        end

        // R4: same-cycle level
        rx_avail = 1; #1;
        check("R4 rda level high", iid, 4'b0100);
        rx_avail = 0; #1;
        check("R4 rda level low", iid, 4'b0001);
        step();

        // R8: transmit empty
        thr_empty = 0; step(); thr_empty = 1; step();
        check("R8 thre rise", iid, 4'b0010);
        thr_write = 1; step(); thr_write = 0;
        check("R8 write clears", iid, 4'b0001);
        thr_empty = 0; step(); thr_empty = 1; step();
        lsr_err = 4'b0001; step(); lsr_err = '0;
        check("R2 rls over thre", iid, 4'b0110);
        rd_iir = 1; step(); rd_iir = 0;
        rd_lsr = 1; step(); rd_lsr = 0;
        check("R8 iid read of other code keeps thre", iid, 4'b0010);
        rd_iir = 1; step(); rd_iir = 0;
        check("R8 iid read clears thre", iid, 4'b0001);

        // R6/R7: timeout
        rx_nonempty = 1; step();
        ticks(3);
        check("R6 before limit", iid, 4'b0001);
        rx_push = 1; step(); rx_push = 0;
        ticks(3);
        check("R6 push restarts", iid, 4'b0001);
        ticks(1);
        check("R6 timeout fires", iid, 4'b1100);
        rd_rbr = 1; rx_pop = 1; step(); rd_rbr = 0; rx_pop = 0;
        check("R7 rbr read clears", iid, 4'b0001);
        ticks(4);
        check("R6 refires", iid, 4'b1100);
        fifo_mode = 0; #1;
        check("R7 no timeout outside fifo mode", iid, 4'b0001);
        ticks(6);
        check("R7 still none outside fifo mode", iid, 4'b0001);
        fifo_mode = 1; step();
        ticks(4);
        check("R6 fires again", iid, 4'b1100);

        // R2/R5/R10 sweep with every latched cause pending
        lsr_err = 4'b1000; modem_delta = 4'b0010; thr_empty = 0; step();
        lsr_err = '0; modem_delta = '0; thr_empty = 1; step();
        for (int m = 0; m < 32; m++) begin
            logic [3:0] exp;
            {rx_avail, en_rls, en_rda, en_thre, en_msr} = 5'(m);
            #1;
            if (en_rls)               exp = 4'b0110;
            else if (en_rda && rx_avail) exp = 4'b0100;
            else if (en_rda)          exp = 4'b1100;
            else if (en_thre)         exp = 4'b0010;
            else if (en_msr)          exp = 4'b0000;
            else                      exp = 4'b0001;
            check("R2/R5 priority sweep", iid, exp);
            check("R10 irq sweep", {3'b0, irq}, {3'b0, ~exp[0]});
        end
        {en_rls, en_rda, en_thre, en_msr} = 4'hF; rx_avail = 0;
        rx_nonempty = 0; step();
        check("R2 after fifo empties", iid, 4'b0110);
        finish_run();
    end
endmodule